// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects an 8-bit core to external memory through a shared low address/data bus and a separate high-address port. The core issues single read or write requests carrying a 16-bit address and one data byte. The controller then runs one bus cycle. It first drives the low address byte while pulsing an address latch enable. It then turns the bus around, asserts an active-low read or write strobe for a programmable number of cycles, and finishes with a one-cycle done pulse. On a read, that pulse comes with the captured byte.

Two small control registers set up the bus. The address space is split into a lower and an upper sector at a start address supplied on an input. Each sector has its own 2-bit wait code, and the sector an access falls in picks the code that lengthens its strobe. A 3-bit mask trims the high-address port from the top down. Each released pin is reported on an ownership vector so that the general-purpose port logic can take it back. A bus keeper holds the level this block last drove on the low bus whenever the bus is not driven. The keeper has its own enable, separate from the interface enable.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset both registers read 0x00, the interface is disabled, `req_ready` and `ale` are 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `hi_own` is 0x00.
- R2: Register select 0 holds the keeper enable in bit 7 and the high mask in bits 2:0. Register select 1 holds the interface enable in bit 7, the upper-sector wait code in bits 3:2 and the lower-sector wait code in bits 1:0. All other bits read as zero whatever was written to them.
- R3: A request accepted at clock edge E gives `ale`=1 with `ad_o` = address[7:0] and `ad_oe`=1 for the one cycle after E. The cycle after that is a turnaround cycle in which no strobe is active. The strobe follows, and `rd_n` and `wr_n` are never low together.
- R4: The strobe stays low for 1, 2, 3 or 3 cycles for wait codes 00, 01, 10 and 11.
- R5: With wait code 11, `req_ready` stays low for one more cycle after the done pulse before the next address can be driven.
- R6: An access whose address is greater than or equal to `upper_base` uses the upper-sector code. Any other access uses the lower-sector code. The code is fixed when the request is accepted.
- R7: `req_done` pulses for one cycle right after the last strobe cycle. For a read, `req_rdata` then equals the value on `ad_i` at the clock edge that ends the last strobe cycle.
- R8: During a write, `ad_oe` stays 1 and `ad_o` equals the write byte from the turnaround cycle through the last strobe cycle. During a read, `ad_oe` is 0 in those cycles.
- R9: With the interface enabled and mask value m (0 to 7), `hi_own` = 0xFF >> m. `hi_o` is the latched address[15:8] ANDed with `hi_own`, so released pins are driven 0.
- R10: With the interface disabled, `req_ready` is 0, requests are ignored, the strobes stay high and `hi_own` is 0x00.
- R11: `keep_on` = keeper enable AND NOT `ad_oe`, whatever the interface enable is. `keep_val` is the value of `ad_o` in the most recent cycle in which `ad_oe` was 1 (0x00 before any drive).
- R12: A request presented while `req_ready` is 0 is ignored. A request held on `req_valid` is accepted on the first edge at which `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select (0 = mask/keeper, 1 = timing/enable) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register read data |
| upper_base | input | 16 | First address of the upper sector |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle and enabled |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read byte, valid with `req_done` |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ad_o | output | 8 | Low address/data output value |
| ad_oe | output | 1 | Low bus output enable |
| ad_i | input | 8 | Low bus input value |
| hi_o | output | 8 | High-address byte (released pins 0) |
| hi_own | output | 8 | Per-pin: 1 = used by the bus, 0 = released |
| keep_on | output | 1 | Keeper holding the low bus |
| keep_val | output | 8 | Level held by the keeper |

## Verification
The bench tries the bus cycle with all four wait codes, with reads and writes, and with addresses on both sides of the sector boundary. It also moves the boundary, which shows whether the sector pick uses the full address compare. The read bus value changes on every cycle, so a capture one cycle early or late gives a different byte. Four patterns test the request handling: back-to-back requests held on `req_valid`, stray pulses while busy, requests while disabled, and code 11 followed at once by another request. Together they show whether the idle gap and the ignore rules hold. All eight mask values are swept, and the keeper is switched on with the interface off, to show that the pin release and the keeper are independent of the enable.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ADDR = 3'd1,
      PH_TURN = 3'd2,
      PH_STRB = 3'd3,
      PH_GAP  = 3'd4
   } phase_e;

   localparam logic [1:0] WAIT_LONG = 2'b11;

   // extra strobe cycles beyond the first for a wait code
   function automatic logic [1:0] strobe_extra(input logic [1:0] code);
      case (code)
         2'b00:   return 2'd0;
         2'b01:   return 2'd1;
         default: return 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs #(
   parameter int DATA_W = 8,
   parameter int MASK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              if_en,
   output logic [1:0]        wait_lo,
   output logic [1:0]        wait_hi,
   output logic [MASK_W-1:0] hi_mask,
   output logic              keep_en
);

   if (DATA_W != 8) begin : g_bad_width
      $error("xbus_cfg_regs: register layout needs DATA_W == 8");
   end
   if (MASK_W > 4) begin : g_bad_mask
      $error("xbus_cfg_regs: mask field must fit below bit 7");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         if_en   <= 1'b0;
         wait_lo <= 2'b00;
         wait_hi <= 2'b00;
         hi_mask <= '0;
         keep_en <= 1'b0;
      end else if (we) begin
         if (sel) begin
            if_en   <= wdata[7];
            wait_hi <= wdata[3:2];
            wait_lo <= wdata[1:0];
         end else begin
            keep_en <= wdata[7];
            hi_mask <= wdata[MASK_W-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (sel) begin
         rdata[7]   = if_en;
         rdata[3:2] = wait_hi;
         rdata[1:0] = wait_lo;
      end else begin
         rdata[7]          = keep_en;
         rdata[MASK_W-1:0] = hi_mask;
      end
   end

   // R2: unused bit positions never read back as one
   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sel ? (rdata[6:4] == 3'b000) : (rdata[6:MASK_W] == '0));

endmodule

// File: rtl/xbus_hi_port.sv
module xbus_hi_port #(
   parameter int HI_W   = 8,
   parameter int MASK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              if_en,
   input  logic [MASK_W-1:0] hi_mask,
   input  logic [HI_W-1:0]   addr_hi,
   output logic [HI_W-1:0]   hi_own,
   output logic [HI_W-1:0]   hi_o
);

   if ((1 << MASK_W) > HI_W) begin : g_bad_mask
      $error("xbus_hi_port: mask range exceeds port width");
   end

   localparam int CW = MASK_W + 2;

   logic [CW-1:0] used_bits;
   assign used_bits = CW'(HI_W) - CW'(hi_mask);

   for (genvar i = 0; i < HI_W; i++) begin : g_pin
      assign hi_own[i] = if_en && (CW'(i) < used_bits);
      assign hi_o[i]   = hi_own[i] & addr_hi[i];
   end

   // R9: pins kept equals width minus mask while enabled
   assert_own_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      if_en |-> ($countones(hi_own) == HI_W - int'(hi_mask)));
   // R10: disabled interface hands every pin back
   assert_release_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !if_en |-> (hi_o == '0));

endmodule

// File: rtl/xbus_keeper.sv
module xbus_keeper #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              keep_en,
   input  logic              ad_oe,
   input  logic [DATA_W-1:0] ad_o,
   output logic              keep_on,
   output logic [DATA_W-1:0] keep_val
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     keep_val <= '0;
      else if (ad_oe) keep_val <= ad_o;
   end

   assign keep_on = keep_en & ~ad_oe;

   // R11: held level does not move while nothing drives the bus
   assert_keep_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ad_oe && $past(!ad_oe)) |-> $stable(keep_val));

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              if_en,
   input  logic [1:0]        wait_lo,
   input  logic [1:0]        wait_hi,
   input  logic [ADDR_W-1:0] upper_base,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              req_done,
   output logic [DATA_W-1:0] req_rdata,
   input  logic [DATA_W-1:0] ad_i,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic [DATA_W-1:0] ad_o,
   output logic              ad_oe,
   output logic [ADDR_W-DATA_W-1:0] addr_hi
);

   localparam int HI_W = ADDR_W - DATA_W;

   phase_e            st;
   logic [1:0]        cnt;
   logic [1:0]        code_q;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   assign req_ready = if_en && (st == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= PH_IDLE;
         cnt       <= 2'd0;
         code_q    <= 2'b00;
         wr_q      <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
         req_done  <= 1'b0;
         req_rdata <= '0;
      end else begin
         req_done <= 1'b0;
         case (st)
            PH_IDLE: if (req_valid && if_en) begin
               wr_q    <= req_write;
               addr_q  <= req_addr;
               wdata_q <= req_wdata;
               code_q  <= (req_addr >= upper_base) ? wait_hi : wait_lo;
               st      <= PH_ADDR;
            end
            PH_ADDR: st <= PH_TURN;
            PH_TURN: begin
               cnt <= strobe_extra(code_q);
               st  <= PH_STRB;
            end
            PH_STRB: begin
               if (cnt == 2'd0) begin
                  req_done <= 1'b1;
                  if (!wr_q) req_rdata <= ad_i;
                  st <= (code_q == WAIT_LONG) ? PH_GAP : PH_IDLE;
               end else begin
                  cnt <= cnt - 2'd1;
               end
            end
            PH_GAP:  st <= PH_IDLE;
            default: st <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      ale   = (st == PH_ADDR);
      rd_n  = !((st == PH_STRB) && !wr_q);
      wr_n  = !((st == PH_STRB) &&  wr_q);
      ad_oe = (st == PH_ADDR) || (wr_q && ((st == PH_TURN) || (st == PH_STRB)));
      ad_o  = (st == PH_ADDR) ? addr_q[DATA_W-1:0] : wdata_q;
   end

   assign addr_hi = addr_q[ADDR_W-1 -: HI_W];

   // R3: strobes are mutually exclusive
   assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));
   // R3: latch enable lasts exactly one cycle and no strobe follows at once
   assert_ale_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> (!ale && rd_n && wr_n));
   // R7: completion only right after a strobe cycle
   assert_done_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> $past(!rd_n || !wr_n));
   // R5: idle gap lasts one cycle
   assert_gap_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_GAP) |=> (st == PH_IDLE));

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int MASK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [ADDR_W-1:0] upper_base,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              req_done,
   output logic [DATA_W-1:0] req_rdata,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic [DATA_W-1:0] ad_o,
   output logic              ad_oe,
   input  logic [DATA_W-1:0] ad_i,
   output logic [ADDR_W-DATA_W-1:0] hi_o,
   output logic [ADDR_W-DATA_W-1:0] hi_own,
   output logic              keep_on,
   output logic [DATA_W-1:0] keep_val
);

   localparam int HI_W = ADDR_W - DATA_W;

   if (HI_W < 1) begin : g_bad_addr
      $error("xbus_ctrl: address must be wider than data");
   end

   logic              if_en;
   logic [1:0]        wait_lo;
   logic [1:0]        wait_hi;
   logic [MASK_W-1:0] hi_mask;
   logic              keep_en;
   logic [HI_W-1:0]   addr_hi;

   xbus_cfg_regs #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel),
      .wdata(reg_wdata), .rdata(reg_rdata), .if_en(if_en),
      .wait_lo(wait_lo), .wait_hi(wait_hi), .hi_mask(hi_mask),
      .keep_en(keep_en));

   xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .if_en(if_en), .wait_lo(wait_lo),
      .wait_hi(wait_hi), .upper_base(upper_base), .req_valid(req_valid),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .req_done(req_done), .req_rdata(req_rdata),
      .ad_i(ad_i), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_o(ad_o),
      .ad_oe(ad_oe), .addr_hi(addr_hi));

   xbus_hi_port #(.HI_W(HI_W), .MASK_W(MASK_W)) u_hi (
      .clk(clk), .rst_n(rst_n), .if_en(if_en), .hi_mask(hi_mask),
      .addr_hi(addr_hi), .hi_own(hi_own), .hi_o(hi_o));

   xbus_keeper #(.DATA_W(DATA_W)) u_keep (
      .clk(clk), .rst_n(rst_n), .keep_en(keep_en), .ad_oe(ad_oe),
      .ad_o(ad_o), .keep_on(keep_on), .keep_val(keep_val));

   // R10: no strobe while the interface is off and idle
   assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!if_en && !req_ready && $past(!if_en) && !ale && !ad_oe) |-> (rd_n && wr_n) || !$past(!if_en));

endmodule

// File: tb/tb_xbus_ctrl.sv
module tb_xbus_ctrl;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_sel = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [15:0] upper_base = 16'h8000;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, req_done;
   logic [7:0]  req_rdata;
   logic        ale, rd_n, wr_n, ad_oe, keep_on;
   logic [7:0]  ad_o, ad_i, hi_o, hi_own, keep_val;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit running = 1'b1;

   always #(CLK_P/2) clk = ~clk;

   xbus_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .upper_base(upper_base),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready), .req_done(req_done),
      .req_rdata(req_rdata), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
      .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .hi_o(hi_o), .hi_own(hi_own),
      .keep_on(keep_on), .keep_val(keep_val));

   // read-side bus value changes every cycle
   assign ad_i = cyc[7:0] ^ 8'hA5;

   // ---------------- behavioural reference ----------------
   int         m_phase = 0;   // 0 idle 1 addr 2 turn 3 strobe 4 gap
   int         m_left = 0;
   bit         m_en = 0, m_keep = 0, m_wr = 0, m_done = 0;
   int         m_wlo = 0, m_whi = 0, m_mask = 0, m_code = 0;
   logic [15:0] m_addr = '0;
   logic [7:0]  m_wdata = '0, m_rdata = '0, m_kval = '0;

   function automatic bit e_oe();
      return (m_phase == 1) || (m_wr && (m_phase == 2 || m_phase == 3));
   endfunction
   function automatic logic [7:0] e_ado();
      return (m_phase == 1) ? m_addr[7:0] : m_wdata;
   endfunction
   function automatic logic [7:0] e_own();
      return m_en ? (8'hFF >> m_mask) : 8'h00;
   endfunction
   function automatic logic [7:0] e_reg(input bit s);
      return s ? {m_en, 3'b000, m_whi[1:0], m_wlo[1:0]}
               : {m_keep, 4'b0000, m_mask[2:0]};
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (e_oe()) m_kval = e_ado();
         m_done = 0;
         case (m_phase)
            0: if (m_en && req_valid) begin
                  m_wr = req_write; m_addr = req_addr; m_wdata = req_wdata;
                  m_code = (req_addr >= upper_base) ? m_whi : m_wlo;
                  m_phase = 1;
               end
            1: m_phase = 2;
            2: begin
                  m_phase = 3;
                  m_left = (m_code == 0) ? 1 : (m_code == 1) ? 2 : 3;
               end
            3: begin
                  m_left--;
                  if (m_left == 0) begin
                     m_done = 1;
                     if (!m_wr) m_rdata = ad_i;
                     m_phase = (m_code == 3) ? 4 : 0;
                  end
               end
            default: m_phase = 0;
         endcase
         if (reg_we) begin
            if (reg_sel) begin
               m_en = reg_wdata[7]; m_whi = reg_wdata[3:2]; m_wlo = reg_wdata[1:0];
            end else begin
               m_keep = reg_wdata[7]; m_mask = reg_wdata[2:0];
            end
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s at cycle %0d: actual %h expected %h",
                  req, what, cyc, act, exp);
      end
   endtask

   // per-cycle comparison, a quarter period after inputs change
   always @(negedge clk) begin
      #(CLK_P/4);
      if (rst_n && running) begin
         chk("R2", "reg_rdata", 16'(reg_rdata), 16'(e_reg(reg_sel)));
         chk("R3", "ale", 16'(ale), 16'(m_phase == 1));
         chk("R4 R6", "rd_n", 16'(rd_n), 16'(!(m_phase == 3 && !m_wr)));
         chk("R4 R6", "wr_n", 16'(wr_n), 16'(!(m_phase == 3 && m_wr)));
         chk("R8", "ad_oe", 16'(ad_oe), 16'(e_oe()));
         if (e_oe()) chk("R3 R8", "ad_o", 16'(ad_o), 16'(e_ado()));
         chk("R5 R10 R12", "req_ready", 16'(req_ready), 16'(m_en && m_phase == 0));
         chk("R7", "req_done", 16'(req_done), 16'(m_done));
         if (m_done && !m_wr) chk("R7", "req_rdata", 16'(req_rdata), 16'(m_rdata));
         chk("R9 R10", "hi_own", 16'(hi_own), 16'(e_own()));
         chk("R9", "hi_o", 16'(hi_o), 16'(m_addr[15:8] & e_own()));
         chk("R11", "keep_on", 16'(keep_on), 16'(m_keep && !e_oe()));
         chk("R11", "keep_val", 16'(keep_val), 16'(m_kval));
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr_reg(input bit s, input logic [7:0] d);
      @(negedge clk);
      reg_sel = s; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic access(input bit w, input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_done) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      running = 1'b0;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #(CLK_P/4);
      // R1: reset state at the ports
      chk("R1", "reset rd_n", 16'(rd_n), 16'd1);
      chk("R1", "reset wr_n", 16'(wr_n), 16'd1);
      chk("R1", "reset ready", 16'(req_ready), 16'd0);
      chk("R1", "reset hi_own", 16'(hi_own), 16'd0);
      chk("R1", "reset ad_oe", 16'(ad_oe), 16'd0);
      chk("R1", "reset reg0", 16'(reg_rdata), 16'd0);

      // R10: request while disabled is ignored
      @(negedge clk);
      req_valid = 1'b1; req_addr = 16'h4321;
      repeat (4) @(negedge clk);
      req_valid = 1'b0;

      // R2: reserved bits written as ones read back zero
      wr_reg(1'b0, 8'h78);
      wr_reg(1'b1, 8'h70);
      // R4 R6: lower code 00, upper code 01
      wr_reg(1'b1, 8'h84);
      access(1'b0, 16'h1234, 8'h00);
      access(1'b1, 16'h9234, 8'h5C);
      access(1'b1, 16'h7FFF, 8'h11);
      access(1'b0, 16'h8000, 8'h00);
      // R4 R5: lower code 10, upper code 11
      wr_reg(1'b1, 8'h8E);
      access(1'b0, 16'h2222, 8'h00);
      access(1'b1, 16'hC0DE, 8'h3A);
      access(1'b0, 16'hF00D, 8'h00);
      // R6: boundary moved
      upper_base = 16'h2000;
      access(1'b0, 16'h1FFF, 8'h00);
      access(1'b0, 16'h2000, 8'h00);
      upper_base = 16'h8000;
      // R9: sweep every mask
      for (int m = 0; m < 8; m++) begin
         wr_reg(1'b0, 8'(m));
         access(1'b0, 16'hFF80 | 16'(m), 8'h00);
      end
      // R12: back-to-back held request and stray pulses while busy
      wr_reg(1'b1, 8'h8D);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 16'hA5A5; req_wdata = 8'h96;
      repeat (20) @(negedge clk);
      req_valid = 1'b0;
      repeat (6) @(negedge clk);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0101;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 16'h0202;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (8) @(negedge clk);
      // R11: keeper on with interface off
      wr_reg(1'b0, 8'h83);
      access(1'b1, 16'h4455, 8'hE7);
      wr_reg(1'b1, 8'h00);
      repeat (4) @(negedge clk);
      wr_reg(1'b0, 8'h00);
      repeat (4) @(negedge clk);
      finish_run();
   end

   // watchdog
   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule